// File: doc/BRIEF.md
# Buffered Time Register Access Port

This block sits between a byte-level serial slave front end and a set of free-running time counters. The front end reports start and stop conditions, complete received bytes, the falling clock edge that closes each acknowledge bit, and the moment a transmitted byte has been consumed. The block decodes the device select byte and a two-byte register address. It keeps one shadow array the size of the time register bank. It also holds a pair of write-enable latches that protect the time registers.

For a read, the shadow array takes a copy of the live counters on the acknowledge edge that follows the read select byte. Every byte of a sequential read is served from that copy, so a multi-byte read returns one coherent instant while the counters keep running. For a write, the same array is preloaded from the live counters on the acknowledge edge that follows the address. Received bytes overwrite their entries. The whole array is handed to the counters in one strobe, but only at a stop that ends a valid write and only while the second enable latch is set. Any other ending throws the staged bytes away.

Top module: `rtc_shadow_port`

## Requirements
- R1: After reset `commitEn` and `addressed` are low, and the status register (address 3Fh) reads 00h.
- R2: Only a select byte whose upper seven bits are 1101111 addresses the block (bit 0 high selects read, low selects write). Any other select byte leaves `addressed` low, and a write that follows it is not committed.
- R3: A sequential read of the time registers (addresses 30h to 37h, byte k at `liveTime[8k+7:8k]`) returns the counter values captured on the `ackFall` that follows the read select byte, even if `liveTime` changes afterwards.
- R4: A write preloads every time byte from `liveTime` on the `ackFall` that follows the low address byte. A time byte that was not received appears in `commitTime` with its preloaded value.
- R5: A write of at least one time byte that ends with `stopEv` while RWEL is set raises `commitEn` for exactly one cycle, in the cycle after `stopEv` is sampled. `commitTime` then holds the staged bytes.
- R6: A start condition that repeats inside a write discards the staged bytes. The stop that follows does not commit, and RWEL is left set.
- R7: A stop during the address phase commits nothing, leaves the status unchanged and drops `addressed`.
- R8: Status encoding: bit 1 is WEL and bit 2 is RWEL. Writing 02h sets WEL alone. Writing 06h sets RWEL only if WEL was already set; otherwise it sets WEL alone. Writing 00h clears both.
- R9: With RWEL clear, a time write is not committed.
- R10: A committed time write clears RWEL and keeps WEL.
- R11: Within the time section the register pointer wraps from 37h back to 30h, for both reads and writes.
- R12: A non-zero high address byte, or a low address byte above 3Fh, drops the transfer: `addressed` goes low and nothing is committed.
- R13: A read of an address outside the time and status sections returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startEv | input | 1 | Start or repeated start seen, one-cycle pulse |
| stopEv | input | 1 | Stop condition seen, one-cycle pulse |
| rxValid | input | 1 | A complete byte was received |
| rxData | input | 8 | Received byte |
| ackFall | input | 1 | Falling clock edge that ends an acknowledge bit |
| txAdv | input | 1 | Current transmit byte was consumed; advance the pointer |
| liveTime | input | NREG*8 | Current value of the running time counters |
| txData | output | 8 | Byte to transmit at the current pointer |
| addressed | output | 1 | Block is selected for the current transfer |
| commitEn | output | 1 | One-cycle strobe that loads `commitTime` into the counters |
| commitTime | output | NREG*8 | Staged time bytes |

## Verification
The hardest case to reach is a snapshot that must stay frozen while the live counters move. The stimulus changes `liveTime` between the capture acknowledge and the first transmitted byte, and the expected bytes come from the value held before the change. The discarded write is just as hard to reach. RWEL must be set first through the two-step status sequence; the write is then cut short by a repeated start, and a second, uninterrupted write must still commit, which shows RWEL survived the discard.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;

  localparam int WEL_BIT  = 1;
  localparam int RWEL_BIT = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_DEVID, S_ADRH, S_ADRL, S_WRITE, S_READ, S_SKIP
  } portState_t;

  typedef struct packed {
    logic loadShadow;
    logic storeByte;
    logic ptrLoad;
    logic ptrAdv;
    logic endWrite;
    logic drop;
  } ctlStrobes_t;

endpackage

// File: rtl/rtc_shadow_ctrl.sv
module rtc_shadow_ctrl
  import rtc_shadow_pkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'b1101111,
  parameter int         ADDR_W = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startEv,
  input  logic        stopEv,
  input  logic        rxValid,
  input  logic [7:0]  rxData,
  input  logic        ackFall,
  input  logic        txAdv,
  output ctlStrobes_t ctl,
  output logic        addressed
);

  portState_t state, nextState;
  logic snapArm, loadArm, hiOk;

  always_comb begin
    ctl       = '0;
    nextState = state;
    if (stopEv) begin
      if (state == S_WRITE) ctl.endWrite = 1'b1;
      else                  ctl.drop     = 1'b1;
      nextState = S_IDLE;
    end else if (startEv) begin
      ctl.drop  = 1'b1;
      nextState = S_DEVID;
    end else if (rxValid) begin
      case (state)
        S_DEVID: begin
          if (rxData[7:1] != DEV_ID) nextState = S_SKIP;
          else if (rxData[0])        nextState = S_READ;
          else                       nextState = S_ADRH;
        end
        S_ADRH: nextState = S_ADRL;
        S_ADRL: begin
          if (hiOk && rxData[7:ADDR_W] == '0) begin
            ctl.ptrLoad = 1'b1;
            nextState   = S_WRITE;
          end else begin
            nextState = S_SKIP;
          end
        end
        S_WRITE: begin
          ctl.storeByte = 1'b1;
          ctl.ptrAdv    = 1'b1;
        end
        default: ;
      endcase
    end else if (ackFall && (snapArm || loadArm)) begin
      ctl.loadShadow = 1'b1;
    end else if (txAdv && state == S_READ) begin
      ctl.ptrAdv = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      snapArm <= 1'b0;
      loadArm <= 1'b0;
      hiOk    <= 1'b0;
    end else begin
      state <= nextState;
      if (stopEv || startEv || ctl.loadShadow) begin
        snapArm <= 1'b0;
        loadArm <= 1'b0;
      end else if (rxValid) begin
        if (state == S_DEVID && rxData[7:1] == DEV_ID && rxData[0]) snapArm <= 1'b1;
        if (ctl.ptrLoad) loadArm <= 1'b1;
        if (state == S_ADRH) hiOk <= (rxData == 8'h00);
      end
    end
  end

  assign addressed = (state == S_ADRH) || (state == S_ADRL) ||
                     (state == S_WRITE) || (state == S_READ);

endmodule

// File: rtl/rtc_shadow_dp.sv
module rtc_shadow_dp
  import rtc_shadow_pkg::*;
#(
  parameter int NREG        = 8,
  parameter int ADDR_W      = 6,
  parameter int TIME_BASE   = 'h30,
  parameter int STATUS_ADDR = 'h3F
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [7:0]        rxData,
  input  logic [NREG*8-1:0] liveTime,
  output logic [7:0]        txData,
  output logic              commitEn,
  output logic [NREG*8-1:0] commitTime
);

  localparam int IDX_W    = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int TIME_END = TIME_BASE + NREG - 1;

  logic [7:0]        shadow [NREG];
  logic [ADDR_W-1:0] ptr;
  logic              timeDirty, stValid, wel, rwel;
  logic [7:0]        stStage;
  logic              inTime, isStatus;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] ptrNext;
  logic [7:0]        statusByte;

  assign inTime   = (int'(ptr) >= TIME_BASE) && (int'(ptr) <= TIME_END);
  assign isStatus = (int'(ptr) == STATUS_ADDR);
  assign idx      = IDX_W'(int'(ptr) - TIME_BASE);

  always_comb begin
    if (inTime && int'(ptr) == TIME_END) ptrNext = ADDR_W'(TIME_BASE);
    else if (isStatus)                   ptrNext = ptr;
    else                                 ptrNext = ptr + 1'b1;
  end

  always_comb begin
    statusByte           = '0;
    statusByte[WEL_BIT]  = wel;
    statusByte[RWEL_BIT] = rwel;
  end

  assign txData = inTime ? shadow[idx] : (isStatus ? statusByte : 8'h00);

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign commitTime[g*8 +: 8] = shadow[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) shadow[i] <= 8'h00;
      ptr       <= '0;
      timeDirty <= 1'b0;
      stValid   <= 1'b0;
      stStage   <= 8'h00;
      wel       <= 1'b0;
      rwel      <= 1'b0;
      commitEn  <= 1'b0;
    end else begin
      commitEn <= 1'b0;
      if (ctl.loadShadow)
        for (int i = 0; i < NREG; i++) shadow[i] <= liveTime[i*8 +: 8];
      if (ctl.ptrLoad) ptr <= rxData[ADDR_W-1:0];
      else if (ctl.ptrAdv) ptr <= ptrNext;
      if (ctl.storeByte) begin
        if (inTime) begin
          shadow[idx] <= rxData;
          timeDirty   <= 1'b1;
        end
        if (isStatus) begin
          stStage <= rxData;
          stValid <= 1'b1;
        end
      end
      if (ctl.drop) begin
        timeDirty <= 1'b0;
        stValid   <= 1'b0;
      end
      if (ctl.endWrite) begin
        timeDirty <= 1'b0;
        stValid   <= 1'b0;
        if (stValid) begin
          wel  <= stStage[WEL_BIT];
          rwel <= stStage[WEL_BIT] & stStage[RWEL_BIT] & wel;
        end else if (timeDirty && rwel) begin
          commitEn <= 1'b1;
          rwel     <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/rtc_shadow_port.sv
module rtc_shadow_port
  import rtc_shadow_pkg::*;
#(
  parameter int         NREG        = 8,
  parameter int         ADDR_W      = 6,
  parameter int         TIME_BASE   = 'h30,
  parameter int         STATUS_ADDR = 'h3F,
  parameter logic [6:0] DEV_ID      = 7'b1101111
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              ackFall,
  input  logic              txAdv,
  input  logic [NREG*8-1:0] liveTime,
  output logic [7:0]        txData,
  output logic              addressed,
  output logic              commitEn,
  output logic [NREG*8-1:0] commitTime
);

  ctlStrobes_t ctl;

  rtc_shadow_ctrl #(.DEV_ID(DEV_ID), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .rxValid(rxValid), .rxData(rxData), .ackFall(ackFall), .txAdv(txAdv),
    .ctl(ctl), .addressed(addressed)
  );

  rtc_shadow_dp #(.NREG(NREG), .ADDR_W(ADDR_W), .TIME_BASE(TIME_BASE),
                  .STATUS_ADDR(STATUS_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxData(rxData), .liveTime(liveTime),
    .txData(txData), .commitEn(commitEn), .commitTime(commitTime)
  );

endmodule

// File: rtl/rtc_shadow_chk.sv
module rtc_shadow_chk (
  input logic clk,
  input logic rstN,
  input logic startEv,
  input logic stopEv,
  input logic addressed,
  input logic commitEn
);

  always_comb begin
    if (!rstN) begin
      p_reset_idle_r1: assert (!commitEn && !addressed);
    end
  end

  p_commit_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    commitEn |=> !commitEn);

  p_commit_after_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    commitEn |-> $past(stopEv));

  p_stop_releases_r7: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !addressed);

  p_restart_no_commit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (startEv && !stopEv) |=> !commitEn);

endmodule

bind rtc_shadow_port rtc_shadow_chk u_chk (
  .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
  .addressed(addressed), .commitEn(commitEn)
);

// File: tb/sim_rtc_shadow_port.sv
module sim_rtc_shadow_port;
  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startEv = 0, stopEv = 0, rxValid = 0, ackFall = 0, txAdv = 0;
  logic [7:0] rxData = 8'h00;
  logic [NREG*8-1:0] liveT = 64'h20_06_05_14_03_12_34_56;
  logic [7:0] txData;
  logic addressed, commitEn;
  logic [NREG*8-1:0] commitTime;

  int checks = 0, fails = 0, commitsSeen = 0, commitsExp = 0;
  bit done = 0;
  logic [7:0] expTx[$];
  string expTxTag[$];
  logic [NREG*8-1:0] expCommit[$];

  always #4 clk = ~clk;

  rtc_shadow_port u0 (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .rxValid(rxValid), .rxData(rxData), .ackFall(ackFall), .txAdv(txAdv),
    .liveTime(liveT), .txData(txData), .addressed(addressed),
    .commitEn(commitEn), .commitTime(commitTime)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitors: transmit bytes and commit strobes against scoreboard queues
  always @(negedge clk) begin
    if (txAdv) begin
      if (expTx.size() == 0) chk("unexpected tx byte", 1, 0);
      else chk(expTxTag.pop_front(), {56'h0, txData}, {56'h0, expTx.pop_front()});
    end
    if (commitEn) begin
      commitsSeen++;
      if (expCommit.size() == 0) chk("R5 unexpected commit", 1, 0);
      else chk("R4/R5 commit value", commitTime, expCommit.pop_front());
    end
  end

  task automatic step(input logic s, input logic p, input logic rv,
                      input logic [7:0] d, input logic af, input logic ta);
    startEv = s; stopEv = p; rxValid = rv; rxData = d; ackFall = af; txAdv = ta;
    @(posedge clk); #1;
    startEv = 0; stopEv = 0; rxValid = 0; rxData = 0; ackFall = 0; txAdv = 0;
    @(posedge clk); #1;
  endtask

  task automatic byteIn(input logic [7:0] d);
    step(0, 0, 1, d, 0, 0);
    step(0, 0, 0, 8'h00, 1, 0);
  endtask

  task automatic doStart(); step(1, 0, 0, 8'h00, 0, 0); endtask
  task automatic doStop();  step(0, 1, 0, 8'h00, 0, 0); endtask

  task automatic setAddr(input logic [7:0] a);
    doStart(); byteIn(8'hDE); byteIn(8'h00); byteIn(a);
  endtask

  task automatic writeOne(input logic [7:0] a, input logic [7:0] d);
    setAddr(a); byteIn(d); doStop();
  endtask

  task automatic readStatus(input logic [7:0] exp, input string tag);
    setAddr(8'h3F); doStart(); byteIn(8'hDF);
    expTx.push_back(exp); expTxTag.push_back(tag);
    step(0, 0, 0, 8'h00, 0, 1);
    doStop();
  endtask

  // sequential read; liveTime switches to liveAfter once the snapshot is taken
  task automatic readSeq(input logic [7:0] a, input int n,
                         input logic [63:0] liveAfter, input string tag);
    logic [63:0] snap;
    int p;
    setAddr(a); doStart(); byteIn(8'hDF);
    snap = liveT;
    liveT = liveAfter;
    p = a;
    for (int i = 0; i < n; i++) begin
      if (p >= 'h30 && p <= 'h37) expTx.push_back(snap[(p - 'h30)*8 +: 8]);
      else expTx.push_back(8'h00);
      expTxTag.push_back(tag);
      step(0, 0, 0, 8'h00, 0, 1);
      p = (p == 'h37) ? 'h30 : p + 1;
    end
    doStop();
  endtask

  function automatic logic [63:0] put(input logic [63:0] v, input int idx, input logic [7:0] b);
    logic [63:0] r;
    r = v;
    r[idx*8 +: 8] = b;
    return r;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 commitEn in reset", commitEn, 0);
    chk("R1 addressed in reset", addressed, 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1 addressed after reset", addressed, 0);
    readStatus(8'h00, "R1 status after reset");

    // R9: locked write is dropped
    writeOne(8'h30, 8'h45);
    chk("R9 no commit while locked", commitsSeen, 0);

    // R8: unlock sequence
    writeOne(8'h3F, 8'h06);
    readStatus(8'h02, "R8 06h without WEL");
    writeOne(8'h3F, 8'h02);
    readStatus(8'h02, "R8 02h sets WEL");
    writeOne(8'h3F, 8'h06);
    readStatus(8'h06, "R8 06h sets RWEL");

    // R4/R5: single byte write, others preloaded
    expCommit.push_back(put(liveT, 2, 8'h11)); commitsExp++;
    writeOne(8'h32, 8'h11);
    chk("R5 one commit", commitsSeen, commitsExp);
    readStatus(8'h02, "R10 RWEL cleared after commit");

    // R11: write wraps within time section
    writeOne(8'h3F, 8'h06);
    expCommit.push_back(put(put(put(liveT, 6, 8'hAA), 7, 8'hBB), 0, 8'hCC)); commitsExp++;
    setAddr(8'h36); byteIn(8'hAA); byteIn(8'hBB); byteIn(8'hCC); doStop();
    chk("R11 wrapped write committed", commitsSeen, commitsExp);

    // R6: repeated start discards
    writeOne(8'h3F, 8'h06);
    setAddr(8'h31); byteIn(8'h77); doStart(); doStop();
    chk("R6 no commit after restart", commitsSeen, commitsExp);
    readStatus(8'h06, "R6 RWEL kept after discard");
    expCommit.push_back(put(liveT, 1, 8'h77)); commitsExp++;
    writeOne(8'h31, 8'h77);
    chk("R6 later write commits", commitsSeen, commitsExp);

    // R2: foreign select byte
    writeOne(8'h3F, 8'h06);
    doStart(); byteIn(8'hA0);
    chk("R2 foreign id not addressed", addressed, 0);
    byteIn(8'h00); byteIn(8'h30); byteIn(8'h99); doStop();
    chk("R2 foreign write not committed", commitsSeen, commitsExp);

    // R7: stop inside address phase
    doStart(); byteIn(8'hDE);
    chk("R2 own id addressed", addressed, 1);
    byteIn(8'h00); doStop();
    chk("R7 addressed dropped", addressed, 0);
    chk("R7 no commit", commitsSeen, commitsExp);
    readStatus(8'h06, "R7 status unchanged");

    // R12: out-of-range address
    doStart(); byteIn(8'hDE); byteIn(8'h01); byteIn(8'h30);
    chk("R12 high byte drops", addressed, 0);
    byteIn(8'h55); doStop();
    doStart(); byteIn(8'hDE); byteIn(8'h00); byteIn(8'h40);
    chk("R12 low byte above range drops", addressed, 0);
    doStop();
    chk("R12 no commit", commitsSeen, commitsExp);

    // R3: snapshot stays while counters move
    liveT = 64'h21_09_08_03_07_23_59_58;
    readSeq(8'h30, 8, 64'h21_09_08_03_08_00_00_00, "R3 snapshot byte");
    readSeq(8'h37, 2, liveT, "R11 read wrap");
    readSeq(8'h10, 1, liveT, "R13 unused address");

    chk("R5 total commits", commitsSeen, commitsExp);
    chk("R3 read queue drained", expTx.size(), 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule